// File: doc/BRIEF.md
# Hitless Switch Delay Aligner

Two radio channels carry the same byte payload. They reach the receiver with a small relative skew, and each has its own frame-start strobe. This block measures that skew in whole bytes and delays whichever stream arrives first, so that both streams present the same byte in the same clock cycle. Once the streams line up, the output can move from one stream to the other without repeating, losing or altering a byte. A protection controller decides when to change streams and raises a request. The block carries out that request at the next aligned frame start, but only once the measured skew has held still for a programmable number of frames.

Both streams advance one byte per clock in a single clock domain. The measured skew is a two's-complement output that the controller can read. A positive value means stream B lags stream A. When the magnitude exceeds the compensation limit of three bytes, a flag is raised and every switch is held back. Frame recovery and the choice of stream lie outside the block.

Top module: `hitless_aligner`

## Requirements
- R1: After synchronous reset, out_sel is 0 (stream A), skew is 0, skew_oor is 0, out_data is 0 and out_sof is 0.
- R2: At each b_sof that follows at least one a_sof, skew takes the signed number of bytes by which B's frame start trails A's. The value is folded into the range -FRAME_LEN/2+1 .. +FRAME_LEN/2, and a negative value means B leads.
- R3: skew_oor is 1 exactly when the most recent measurement lies outside -MAX_SKEW..+MAX_SKEW (default ±3), and it is 0 for a measurement of exactly ±3.
- R4: For an in-range skew k, the earlier stream is delayed by |k| bytes. Once settled, out_data is stream A's byte delayed by max(k,0)+1 cycles, and out_sof marks the byte that stream A sent with a_sof.
- R5: out_sel changes only in the cycle where out_sof is 1. A pulse on sw_req makes out_sel toggle (0 = A, 1 = B) once.
- R6: No switch takes place while skew_oor is 1. The request stays pending and is carried out once the conditions are met.
- R7: A switch requires hold_frames consecutive in-range measurements after the first measurement that shows a new value, each equal to the one before it.
- R8: Across a switch, out_data keeps the same byte sequence with no byte repeated or dropped.
- R9: At most one of the two streams has a nonzero delay at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte per stream per cycle |
| rst | input | 1 | Synchronous active-high reset |
| a_data | input | 8 | Stream A byte |
| a_sof | input | 1 | Stream A frame-start strobe |
| b_data | input | 8 | Stream B byte |
| b_sof | input | 1 | Stream B frame-start strobe |
| sw_req | input | 1 | One-cycle pulse requesting a change of active stream |
| hold_frames | input | HOLD_W | Number of equal in-range measurements required before a switch |
| out_data | output | 8 | Aligned byte from the active stream |
| out_sof | output | 1 | Frame-start strobe aligned with out_data |
| out_sel | output | 1 | Active stream, 0 = A, 1 = B |
| skew | output | SKEW_W | Signed measured skew in bytes |
| skew_oor | output | 1 | Measured skew exceeds the compensation range |

## Verification
skew and skew_oor register at the edge that closes the cycle in which b_sof is seen. After any change of skew the bench therefore waits at least two frames before it reads them. For a skew k, out_data shows at an edge the stream-A byte sent max(k,0) cycles before that edge. The bench drives each byte from a running index and compares against the byte for index minus max(k,0), sampling a quarter period after the edge. A switch can only land at an aligned frame start after hold_frames further measurements. The bench therefore waits through a window, checking every cycle, and when out_sel flips it checks out_sof and the data on that cycle.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
    parameter int BYTE_W = 8;

    typedef struct packed {
        logic              sof;
        logic [BYTE_W-1:0] data;
    } lane_t;

    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } sel_e;
endpackage

// File: rtl/hsa_delay_line.sv
module hsa_delay_line
    import hsa_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_t            lane_i,
    input  logic [DLY_W-1:0] tap_sel,
    output lane_t            lane_o
);
    lane_t stg [DEPTH+1];

    assign stg[0] = lane_i;

    for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    always_comb begin
        lane_o = stg[0];
        for (int k = 1; k <= DEPTH; k++) begin
            if (tap_sel == DLY_W'(k)) lane_o = stg[k];
        end
    end
endmodule

// File: rtl/hsa_skew_meter.sv
module hsa_skew_meter #(
    parameter int FRAME_LEN = 2430,
    parameter int MAX_SKEW  = 3,
    parameter int HOLD_W    = 4,
    parameter int CNT_W     = 12,
    parameter int SKEW_W    = 13,
    parameter int DLY_W     = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     a_sof,
    input  logic                     b_sof,
    input  logic [HOLD_W-1:0]        hold_frames,
    output logic signed [SKEW_W-1:0] skew_q,
    output logic                     oor_q,
    output logic [DLY_W-1:0]         dly_a,
    output logic [DLY_W-1:0]         dly_b,
    output logic                     ready
);
    localparam int HALF = FRAME_LEN / 2;
    localparam logic [CNT_W-1:0]         LAST  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0]         HALFC = CNT_W'(HALF);
    localparam logic signed [SKEW_W-1:0] FLEN  = SKEW_W'(FRAME_LEN);
    localparam logic signed [SKEW_W-1:0] LIM_P = SKEW_W'(MAX_SKEW);
    localparam logic signed [SKEW_W-1:0] LIM_N = -LIM_P;

    logic [CNT_W-1:0]         pos_cnt;
    logic [CNT_W-1:0]         pos;
    logic                     a_seen;
    logic                     have_prev;
    logic [HOLD_W-1:0]        stable;
    logic signed [SKEW_W-1:0] pos_s;
    logic signed [SKEW_W-1:0] meas;
    logic                     in_rng;
    logic                     take;

    // Byte position inside stream A's frame, 0 on the strobe cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_cnt <= '0;
            a_seen  <= 1'b0;
        end else begin
            if (a_sof) begin
                pos_cnt <= CNT_W'(1);
                a_seen  <= 1'b1;
            end else if (pos_cnt == LAST) begin
                pos_cnt <= '0;
            end else begin
                pos_cnt <= pos_cnt + CNT_W'(1);
            end
        end
    end

    always_comb begin
        pos    = a_sof ? '0 : pos_cnt;
        pos_s  = $signed({{(SKEW_W-CNT_W){1'b0}}, pos});
        meas   = (pos <= HALFC) ? pos_s : (pos_s - FLEN);
        in_rng = (meas <= LIM_P) && (meas >= LIM_N);
        take   = b_sof && (a_seen || a_sof);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            skew_q    <= '0;
            oor_q     <= 1'b0;
            dly_a     <= '0;
            dly_b     <= '0;
            have_prev <= 1'b0;
            stable    <= '0;
        end else if (take) begin
            skew_q    <= meas;
            oor_q     <= !in_rng;
            have_prev <= 1'b1;
            if (in_rng) begin
                dly_a <= (meas > 0) ? DLY_W'(meas)  : '0;
                dly_b <= (meas < 0) ? DLY_W'(-meas) : '0;
            end
            if (in_rng && have_prev && !oor_q && (meas == skew_q)) begin
                if (stable != '1) stable <= stable + HOLD_W'(1);
            end else begin
                stable <= '0;
            end
        end
    end

    assign ready = have_prev && !oor_q && (stable >= hold_frames);
endmodule

// File: rtl/hsa_switch_ctl.sv
module hsa_switch_ctl
    import hsa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sw_req,
    input  logic ready,
    input  logic frame_edge,
    output sel_e sel_q,
    output sel_e sel_nxt
);
    logic pending;
    logic fire;

    assign fire    = pending && ready && frame_edge;
    assign sel_nxt = fire ? sel_e'(~sel_q) : sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            sel_q   <= SEL_A;
        end else begin
            pending <= sw_req || (pending && !fire);
            sel_q   <= sel_nxt;
        end
    end
endmodule

// File: rtl/hitless_aligner.sv
module hitless_aligner
    import hsa_pkg::*;
#(
    parameter int FRAME_LEN = 2430,
    parameter int MAX_SKEW  = 3,
    parameter int HOLD_W    = 4,
    localparam int CNT_W    = $clog2(FRAME_LEN),
    localparam int SKEW_W   = CNT_W + 1,
    localparam int DLY_W    = $clog2(MAX_SKEW + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [BYTE_W-1:0]        a_data,
    input  logic                     a_sof,
    input  logic [BYTE_W-1:0]        b_data,
    input  logic                     b_sof,
    input  logic                     sw_req,
    input  logic [HOLD_W-1:0]        hold_frames,
    output logic [BYTE_W-1:0]        out_data,
    output logic                     out_sof,
    output logic                     out_sel,
    output logic signed [SKEW_W-1:0] skew,
    output logic                     skew_oor
);
    lane_t            la_in, lb_in, la_d, lb_d, pick;
    logic [DLY_W-1:0] dly_a, dly_b;
    logic             ready;
    sel_e             sel_q, sel_nxt;

    assign la_in = '{sof: a_sof, data: a_data};
    assign lb_in = '{sof: b_sof, data: b_data};

    hsa_skew_meter #(
        .FRAME_LEN(FRAME_LEN), .MAX_SKEW(MAX_SKEW), .HOLD_W(HOLD_W),
        .CNT_W(CNT_W), .SKEW_W(SKEW_W), .DLY_W(DLY_W)
    ) u_meter (
        .clk(clk), .rst(rst), .a_sof(a_sof), .b_sof(b_sof),
        .hold_frames(hold_frames), .skew_q(skew), .oor_q(skew_oor),
        .dly_a(dly_a), .dly_b(dly_b), .ready(ready)
    );

    hsa_delay_line #(.DEPTH(MAX_SKEW), .DLY_W(DLY_W)) u_dly_a (
        .clk(clk), .rst(rst), .lane_i(la_in), .tap_sel(dly_a), .lane_o(la_d)
    );

    hsa_delay_line #(.DEPTH(MAX_SKEW), .DLY_W(DLY_W)) u_dly_b (
        .clk(clk), .rst(rst), .lane_i(lb_in), .tap_sel(dly_b), .lane_o(lb_d)
    );

    hsa_switch_ctl u_ctl (
        .clk(clk), .rst(rst), .sw_req(sw_req), .ready(ready),
        .frame_edge(la_d.sof), .sel_q(sel_q), .sel_nxt(sel_nxt)
    );

    assign pick = (sel_nxt == SEL_B) ? lb_d : la_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_sof  <= 1'b0;
        end else begin
            out_data <= pick.data;
            out_sof  <= pick.sof;
        end
    end

    assign out_sel = (sel_q == SEL_B);
endmodule

// File: rtl/hitless_aligner_chk.sv
module hitless_aligner_chk #(
    parameter int SKEW_W   = 13,
    parameter int DLY_W    = 2,
    parameter int MAX_SKEW = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     out_sel,
    input logic                     out_sof,
    input logic                     out_data_nz,
    input logic signed [SKEW_W-1:0] skew,
    input logic                     skew_oor,
    input logic [DLY_W-1:0]         dly_a,
    input logic [DLY_W-1:0]         dly_b
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_sel && !out_sof && !out_data_nz && skew == 0 && !skew_oor));

    // R3
    oor_high_chk: assert property (@(posedge clk) disable iff (rst)
        skew_oor |-> (skew > MAX_SKEW || skew < -MAX_SKEW));

    // R3
    oor_low_chk: assert property (@(posedge clk) disable iff (rst)
        !skew_oor |-> (skew <= MAX_SKEW && skew >= -MAX_SKEW));

    // R5
    sel_at_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_sel) |-> out_sof);

    // R6
    no_switch_oor_chk: assert property (@(posedge clk) disable iff (rst)
        $past(skew_oor) |-> $stable(out_sel));

    // R9
    single_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !((dly_a != '0) && (dly_b != '0)));
endmodule

bind hitless_aligner hitless_aligner_chk #(
    .SKEW_W(SKEW_W), .DLY_W(DLY_W), .MAX_SKEW(MAX_SKEW)
) u_chk (
    .clk(clk), .rst(rst), .out_sel(out_sel), .out_sof(out_sof),
    .out_data_nz(|out_data), .skew(skew), .skew_oor(skew_oor),
    .dly_a(dly_a), .dly_b(dly_b)
);

// File: tb/hitless_aligner_bench.sv
module hitless_aligner_bench;
    localparam int CLK_P = 10;
    localparam int FL    = 16;
    localparam int HW    = 4;
    localparam int SW    = $clog2(FL) + 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [7:0]           a_data, b_data;
    logic                 a_sof, b_sof;
    logic                 sw_req = 1'b0;
    logic [HW-1:0]        hold_frames = HW'(3);
    logic [7:0]           out_data;
    logic                 out_sof, out_sel;
    logic signed [SW-1:0] skew;
    logic                 skew_oor;

    int gcnt = 1000;
    int k    = 0;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic [7:0] pay(int n);
        return n[7:0] ^ 8'h5A;
    endfunction

    assign a_data = pay(gcnt);
    assign a_sof  = (gcnt % FL) == 0;
    assign b_data = pay(gcnt - k);
    assign b_sof  = ((gcnt - k) % FL) == 0;

    always #(CLK_P/2) clk = ~clk;
    always @(negedge clk) gcnt <= gcnt + 1;

    hitless_aligner #(.FRAME_LEN(FL), .MAX_SKEW(3), .HOLD_W(HW)) u_hitless_aligner (
        .clk(clk), .rst(rst), .a_data(a_data), .a_sof(a_sof),
        .b_data(b_data), .b_sof(b_sof), .sw_req(sw_req),
        .hold_frames(hold_frames), .out_data(out_data), .out_sof(out_sof),
        .out_sel(out_sel), .skew(skew), .skew_oor(skew_oor)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic wait_frames(input int n);
        repeat (n * FL) step();
    endtask

    function automatic int lag();
        return (k > 0) ? k : 0;
    endfunction

    task automatic pulse_req();
        sw_req = 1'b1;
        step();
        sw_req = 1'b0;
    endtask

    // Checks data and strobe every cycle; checks sof and data when out_sel flips.
    task automatic watch(input int cycles, input string req, output bit flipped);
        logic prev_sel;
        flipped  = 1'b0;
        prev_sel = out_sel;
        for (int c = 0; c < cycles; c++) begin
            step();
            chk(out_data == pay(gcnt - lag()), "R8", "data continuity",
                out_data, pay(gcnt - lag()));
            chk(out_sof == (((gcnt - lag()) % FL) == 0), "R4", "aligned sof",
                out_sof, ((gcnt - lag()) % FL) == 0);
            if (out_sel != prev_sel) begin
                chk(flipped == 1'b0, req, "single toggle", 1, 0);
                chk(out_sof == 1'b1, "R5", "switch at frame start", out_sof, 1);
                flipped = 1'b1;
            end
            prev_sel = out_sel;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk(out_sel == 1'b0, "R1", "out_sel after reset", out_sel, 0);
        chk(skew == 0, "R1", "skew after reset", skew, 0);
        chk(skew_oor == 1'b0, "R1", "skew_oor after reset", skew_oor, 0);
        chk(out_data == 8'h00, "R1", "out_data after reset", out_data, 0);
        chk(out_sof == 1'b0, "R1", "out_sof after reset", out_sof, 0);
        rst = 1'b0;
    endtask

    task automatic t_measure(input int kk, input bit exp_oor);
        k = kk;
        wait_frames(2);
        chk(skew == kk, "R2", "measured skew", skew, kk);
        chk(skew_oor == exp_oor, "R3", "out-of-range flag", skew_oor, exp_oor);
        if (!exp_oor) begin
            for (int c = 0; c < 20; c++) begin
                step();
                chk(out_data == pay(gcnt - lag()), "R4", "aligned data",
                    out_data, pay(gcnt - lag()));
            end
        end
    endtask

    task automatic t_switch_hold(input int kk);
        bit   fl;
        logic sel0;
        k = kk;
        wait_frames(1);
        sel0 = out_sel;
        pulse_req();
        wait_frames(1);
        chk(out_sel == sel0, "R7", "no switch before hold count", out_sel, sel0);
        watch(6 * FL, "R7", fl);
        chk(fl == 1'b1, "R7", "switch after hold count", fl, 1);
        chk(out_sel == !sel0, "R5", "active stream toggled", out_sel, !sel0);
    endtask

    task automatic t_blocked();
        bit   fl;
        logic sel0;
        k = 5;
        wait_frames(2);
        chk(skew_oor == 1'b1, "R6", "flag set before blocked request", skew_oor, 1);
        sel0 = out_sel;
        pulse_req();
        for (int c = 0; c < 4 * FL; c++) begin
            step();
            if (out_sel != sel0) chk(1'b0, "R6", "switch while out of range", out_sel, sel0);
        end
        chk(out_sel == sel0, "R6", "held while out of range", out_sel, sel0);
        k = 1;
        wait_frames(2);
        watch(6 * FL, "R6", fl);
        chk(fl == 1'b1 || out_sel != sel0, "R6", "pending request served", out_sel, !sel0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_measure(2, 1'b0);
        t_measure(-3, 1'b0);
        t_measure(3, 1'b0);
        t_measure(0, 1'b0);
        t_measure(4, 1'b1);
        t_measure(-4, 1'b1);
        t_measure(-1, 1'b0);
        t_switch_hold(2);
        t_switch_hold(-2);
        t_blocked();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule